// File: doc/BRIEF.md
# Planar Pixel Write/Read Datapath

This block sits between an 8-bit host data port and four byte-wide memory planes that share one address. When the host writes a byte, it produces four plane bytes and a per-plane write strobe. The plane bytes come from one of four write modes. These modes combine a right rotation of the host byte, a per-plane constant fill, a logic operation against the read latches, and a bit mask that keeps selected bit positions at their latched value. When the host reads, all four plane bytes are captured into latches. The host then gets back either the byte of one chosen plane, or a colour-compare byte that marks the pixel positions whose plane bits match a programmed colour. Planes flagged as don't-care are left out of that comparison.

A small controller handles each transfer. It uses these named states:
- ST_IDLE: accepts requests and raises `host_ready`.
- ST_WRITE: one cycle that drives the write strobes.
- ST_RD_REQ: issues the memory read.
- ST_RD_CAP: loads the latches from the returned data.
- ST_RD_RET: returns the result with `host_rvalid`.

The controller has these transitions:
- ST_IDLE goes to ST_RD_REQ on a read request. A read wins if a read and a write arrive together.
- ST_IDLE goes to ST_WRITE on a write request alone.
- ST_WRITE goes back to ST_IDLE.
- ST_RD_REQ goes to ST_RD_CAP, then to ST_RD_RET, then back to ST_IDLE, one state per cycle.

Address decoding and the memory itself are outside the block. The memory answers a read strobe with registered data one cycle later.

Top module: `planar_gfx_dp`

## Requirements
- R1: After reset, every control register is 0 except the bit mask (0xFF) and the plane write mask (0xF). `host_ready` is 1, and `mem_we`, `mem_rd` and `host_rvalid` are 0.
- R2: Control registers are written through `reg_wr`/`reg_idx`/`reg_wdata`, and writes to unlisted indices have no effect. The indices are:
  - 0: fill value, bits 3:0.
  - 1: fill enable, bits 3:0.
  - 2: compare colour, bits 3:0.
  - 3: rotate count in bits 2:0 and logic function in bits 4:3.
  - 4: read plane, bits 1:0.
  - 5: write mode in bits 1:0 and compare-read enable in bit 3.
  - 6: don't-care, bits 3:0.
  - 7: bit mask, bits 7:0.
  - 8: plane write mask, bits 3:0.
- R3: A write accepted in ST_IDLE drives `mem_we` equal to the plane write mask for exactly the following cycle. Plane p occupies bits 8p+7:8p of `mem_wdata` and `mem_rdata`. Only planes with a 1 in the mask change.
- R4: The host byte is rotated right by the rotate count before it is used in write modes 0 and 3.
- R5: The function field selects how the source byte combines with the plane's latch: 0 passes it through, 1 ANDs it, 2 ORs it and 3 XORs it. This applies in write modes 0, 2 and 3.
- R6: In write mode 0, a plane whose fill-enable bit is 1 uses its fill bit replicated over 8 bits. Other planes use the rotated host byte.
- R7: In write mode 1, each plane receives its latch byte unchanged.
- R8: In write mode 2, plane n uses bit n of the unrotated host byte replicated over 8 bits.
- R9: In write mode 3, every plane uses its fill bit replicated over 8 bits, and the rotated host byte ANDed with the bit mask acts as the mask.
- R10: Any bit position that is 0 in the effective mask takes the plane's latch value.
- R11: A read accepted in ST_IDLE pulses `mem_rd` in the next cycle and captures `mem_rdata` into the latches one cycle later. It raises `host_rvalid` for one cycle in the third cycle after acceptance. A read has priority over a simultaneous write.
- R12: With compare-read off, `host_rdata` is the latch byte of the plane chosen by the read plane field.
- R13: With compare-read on, bit i of `host_rdata` is 1 when every plane whose don't-care bit is 0 has bit i equal to that plane's compare-colour bit.
- R14: Host requests made while `host_ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_idx | input | 4 | Control register index |
| reg_wdata | input | 8 | Control register write data |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_wdata | input | 8 | Host write byte |
| host_ready | output | 1 | Block idle, request accepted this cycle |
| host_rdata | output | 8 | Read result |
| host_rvalid | output | 1 | Read result valid |
| mem_rd | output | 1 | Plane read strobe |
| mem_rdata | input | 32 | Plane bytes, returned one cycle after `mem_rd` |
| mem_we | output | 4 | Per-plane write strobe |
| mem_wdata | output | 32 | Plane bytes to write |

## Verification
The write path is swept over every write mode and every logic function. Rotate counts, fill values, fill enables, bit masks, plane masks and latch contents all vary from one write to the next. This separates a wrong rotation direction, a swapped function code, a plane-index mix-up in the fill or spread logic, and a mask that falls back to the wrong source. Compare reads cover all 16 colours under several don't-care patterns, which exposes a polarity inversion or an excluded plane that still takes part. Normal reads cover each plane select. Separate cases check read-over-write priority, requests made while busy, writes to unlisted register indices, and the state left by reset.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
    localparam int PLANES = 4;
    localparam int DW     = 8;
    localparam int ROT_W  = $clog2(DW);
    localparam int SEL_W  = $clog2(PLANES);
    localparam int IDX_W  = 4;

    typedef enum logic [1:0] {
        WM_DIRECT = 2'd0,
        WM_LATCH  = 2'd1,
        WM_SPREAD = 2'd2,
        WM_MASKED = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } func_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RD_REQ,
        ST_RD_CAP,
        ST_RD_RET
    } state_e;

    typedef struct packed {
        logic [PLANES-1:0] fill_val;
        logic [PLANES-1:0] fill_en;
        logic [PLANES-1:0] cmp_col;
        logic [PLANES-1:0] dont_care;
        logic [PLANES-1:0] plane_we;
        logic [DW-1:0]     bit_mask;
        logic [ROT_W-1:0]  rot;
        func_e             func;
        logic [SEL_W-1:0]  rd_sel;
        wmode_e            wmode;
        logic              cmp_mode;
    } cfg_t;

    function automatic logic [DW-1:0] rot_right(input logic [DW-1:0] v,
                                                input logic [ROT_W-1:0] n);
        logic [2*DW-1:0] t;
        t = {v, v} >> n;
        return t[DW-1:0];
    endfunction
endpackage

// File: rtl/pgd_regs.sv
module pgd_regs
    import pgd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DW-1:0]    reg_wdata,
    output cfg_t             cfg
);
    localparam logic [IDX_W-1:0] IX_FILL = 4'd0;
    localparam logic [IDX_W-1:0] IX_FEN  = 4'd1;
    localparam logic [IDX_W-1:0] IX_CCOL = 4'd2;
    localparam logic [IDX_W-1:0] IX_ROTF = 4'd3;
    localparam logic [IDX_W-1:0] IX_RSEL = 4'd4;
    localparam logic [IDX_W-1:0] IX_MODE = 4'd5;
    localparam logic [IDX_W-1:0] IX_DC   = 4'd6;
    localparam logic [IDX_W-1:0] IX_MASK = 4'd7;
    localparam logic [IDX_W-1:0] IX_PWE  = 4'd8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg          <= '0;
            cfg.bit_mask <= '1;
            cfg.plane_we <= '1;
        end else if (reg_wr) begin
            case (reg_idx)
                IX_FILL: cfg.fill_val  <= reg_wdata[PLANES-1:0];
                IX_FEN:  cfg.fill_en   <= reg_wdata[PLANES-1:0];
                IX_CCOL: cfg.cmp_col   <= reg_wdata[PLANES-1:0];
                IX_ROTF: begin
                    cfg.rot  <= reg_wdata[ROT_W-1:0];
                    cfg.func <= func_e'(reg_wdata[ROT_W+1:ROT_W]);
                end
                IX_RSEL: cfg.rd_sel    <= reg_wdata[SEL_W-1:0];
                IX_MODE: begin
                    cfg.wmode    <= wmode_e'(reg_wdata[1:0]);
                    cfg.cmp_mode <= reg_wdata[3];
                end
                IX_DC:   cfg.dont_care <= reg_wdata[PLANES-1:0];
                IX_MASK: cfg.bit_mask  <= reg_wdata;
                IX_PWE:  cfg.plane_we  <= reg_wdata[PLANES-1:0];
                default: ;
            endcase
        end
    end

    // R2
    mode_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IX_MODE) |=> (cfg.wmode == wmode_e'($past(reg_wdata[1:0]))));
endmodule

// File: rtl/pgd_wr_path.sv
module pgd_wr_path
    import pgd_pkg::*;
(
    input  cfg_t                         cfg,
    input  logic [DW-1:0]                host_byte,
    input  logic [PLANES-1:0][DW-1:0]    latch,
    output logic [PLANES-1:0][DW-1:0]    wr_byte
);
    logic [DW-1:0] rot_byte;
    logic [DW-1:0] eff_mask;

    always_comb begin
        rot_byte = rot_right(host_byte, cfg.rot);
        eff_mask = (cfg.wmode == WM_MASKED) ? (rot_byte & cfg.bit_mask) : cfg.bit_mask;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [DW-1:0] src;
        logic [DW-1:0] alu;
        logic [DW-1:0] res;

        always_comb begin
            unique case (cfg.wmode)
                WM_DIRECT: src = cfg.fill_en[p] ? {DW{cfg.fill_val[p]}} : rot_byte;
                WM_SPREAD: src = {DW{host_byte[p]}};
                WM_MASKED: src = {DW{cfg.fill_val[p]}};
                default:   src = latch[p];
            endcase
            unique case (cfg.func)
                FN_AND:  alu = src & latch[p];
                FN_OR:   alu = src | latch[p];
                FN_XOR:  alu = src ^ latch[p];
                default: alu = src;
            endcase
            if (cfg.wmode == WM_LATCH)
                res = latch[p];
            else
                res = (alu & eff_mask) | (latch[p] & ~eff_mask);
        end

        assign wr_byte[p] = res;
    end
endmodule

// File: rtl/pgd_rd_path.sv
module pgd_rd_path
    import pgd_pkg::*;
(
    input  cfg_t                         cfg,
    input  logic [PLANES-1:0][DW-1:0]    latch,
    output logic [DW-1:0]                rd_byte
);
    logic [DW-1:0] match;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic [PLANES-1:0] column;
        for (genvar p = 0; p < PLANES; p++) begin : g_col
            assign column[p] = latch[p][i];
        end
        assign match[i] = &(~(column ^ cfg.cmp_col) | cfg.dont_care);
    end

    always_comb begin
        if (cfg.cmp_mode)
            rd_byte = match;
        else
            rd_byte = latch[cfg.rd_sel];
    end
endmodule

// File: rtl/planar_gfx_dp.sv
module planar_gfx_dp
    import pgd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [DW-1:0]        reg_wdata,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [DW-1:0]        host_wdata,
    output logic                 host_ready,
    output logic [DW-1:0]        host_rdata,
    output logic                 host_rvalid,
    output logic                 mem_rd,
    input  logic [PLANES*DW-1:0] mem_rdata,
    output logic [PLANES-1:0]    mem_we,
    output logic [PLANES*DW-1:0] mem_wdata
);
    cfg_t                      cfg;
    state_e                    state_q, state_d;
    logic [DW-1:0]             wbyte_q;
    logic [PLANES-1:0][DW-1:0] latch_q;
    logic [PLANES-1:0][DW-1:0] wr_byte;
    logic [DW-1:0]             rd_byte;

    pgd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .cfg       (cfg)
    );

    pgd_wr_path u_wr (
        .cfg       (cfg),
        .host_byte (wbyte_q),
        .latch     (latch_q),
        .wr_byte   (wr_byte)
    );

    pgd_rd_path u_rd (
        .cfg     (cfg),
        .latch   (latch_q),
        .rd_byte (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_rd)      state_d = ST_RD_REQ;
                else if (host_wr) state_d = ST_WRITE;
            end
            ST_WRITE:  state_d = ST_IDLE;
            ST_RD_REQ: state_d = ST_RD_CAP;
            ST_RD_CAP: state_d = ST_RD_RET;
            ST_RD_RET: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        host_ready  = 1'b0;
        host_rvalid = 1'b0;
        mem_rd      = 1'b0;
        mem_we      = '0;
        unique case (state_q)
            ST_IDLE:   host_ready  = 1'b1;
            ST_WRITE:  mem_we      = cfg.plane_we;
            ST_RD_REQ: mem_rd      = 1'b1;
            ST_RD_CAP: ;
            ST_RD_RET: host_rvalid = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbyte_q <= '0;
            latch_q <= '0;
        end else begin
            if (state_q == ST_IDLE && host_wr && !host_rd)
                wbyte_q <= host_wdata;
            if (state_q == ST_RD_CAP)
                latch_q <= mem_rdata;
        end
    end

    assign mem_wdata  = wr_byte;
    assign host_rdata = rd_byte;

    // R3
    we_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |-> $past(host_wr && host_ready));

    // R10
    mask_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |-> (((mem_wdata ^ latch_q) & ~{PLANES{cfg.bit_mask}}) == '0));

    // R11
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(mem_rd, 2));

    // R11
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R14
    rd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(host_rd && host_ready));

    // R3
    no_rd_we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && (|mem_we)));
endmodule

// File: tb/planar_gfx_dp_bench.sv
module planar_gfx_dp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        mem_rd;
    logic [31:0] mem_rdata;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;

    logic [31:0] mem_word;
    logic        pre_en = 1'b0;
    logic [31:0] pre_val = '0;

    int chk_cnt = 0;
    int fail_cnt = 0;

    always #10 clk = ~clk;

    planar_gfx_dp u_planar_gfx_dp (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (pre_en) mem_word <= pre_val;
        else begin
            for (int p = 0; p < 4; p++)
                if (mem_we[p]) mem_word[p*8 +: 8] <= mem_wdata[p*8 +: 8];
        end
        if (mem_rd) mem_rdata <= mem_word;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_reg(input int idx, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 4'(idx); reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic preload(input logic [31:0] val);
        @(negedge clk);
        pre_en = 1'b1; pre_val = val;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [7:0] exp);
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R11 mem_rd pulse", {31'b0, mem_rd}, 32'd1);
        @(negedge clk);
        @(negedge clk);
        check("R11 rvalid", {31'b0, host_rvalid}, 32'd1);
        check(req, {24'b0, host_rdata}, {24'b0, exp});
    endtask

    task automatic do_write(input logic [7:0] d, input logic [3:0] exp_we,
                            input logic [31:0] exp_data);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        check("R3 mem_we", {28'b0, mem_we}, {28'b0, exp_we});
        check("R4-R10 write data", mem_wdata, exp_data);
        @(negedge clk);
        check("R3 back to ready", {31'b0, host_ready}, 32'd1);
    endtask

    function automatic logic [7:0] rotr8(input logic [7:0] v, input int n);
        logic [15:0] t;
        t = {v, v} >> n;
        return t[7:0];
    endfunction

    function automatic logic [7:0] exp_plane(input int wm, input int f, input int rot,
            input logic [3:0] fv, input logic [3:0] fe, input logic [7:0] bm,
            input logic [7:0] d, input logic [7:0] lat, input int p);
        logic [7:0] r, s, a, m;
        r = rotr8(d, rot);
        m = bm;
        case (wm)
            0: s = fe[p] ? {8{fv[p]}} : r;
            2: s = {8{d[p]}};
            3: begin s = {8{fv[p]}}; m = r & bm; end
            default: return lat;
        endcase
        case (f)
            1: a = s & lat;
            2: a = s | lat;
            3: a = s ^ lat;
            default: a = s;
        endcase
        return (a & m) | (lat & ~m);
    endfunction

    initial begin
        #3000000;
        fail_cnt++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

    initial begin
        logic [31:0] pat, expw, expm;
        logic [7:0]  d, bm, cmpexp;
        logic [3:0]  fv, fe, pm;
        int          rot, idx;

        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 host_ready", {31'b0, host_ready}, 32'd1);
        check("R1 mem_we", {28'b0, mem_we}, 32'd0);
        check("R1 mem_rd", {31'b0, mem_rd}, 32'd0);
        check("R1 host_rvalid", {31'b0, host_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'b0, host_ready}, 32'd1);

        // R1: default registers: plane 0 read, pass-through full-mask write to all planes
        preload(32'h5A3CF00F);
        do_read("R1 R12 default read plane 0", 8'h0F);
        do_write(8'h96, 4'hF, 32'h96969696);
        @(negedge clk);
        check("R1 R3 memory after default write", mem_word, 32'h96969696);

        // R2: unlisted index leaves behaviour unchanged
        set_reg(9, 8'h00);
        set_reg(15, 8'h00);
        do_write(8'h21, 4'hF, 32'h21212121);

        // Main write sweep: R4 R5 R6 R7 R8 R9 R10 R3
        idx = 0;
        for (int wm = 0; wm < 4; wm++) begin
            for (int f = 0; f < 4; f++) begin
                for (int k = 0; k < 5; k++) begin
                    pat = 32'h9C5AE137 ^ (32'(idx) * 32'h01030507);
                    rot = (idx * 3 + k) % 8;
                    d   = 8'h3C ^ 8'(idx * 37);
                    fv  = 4'(idx) ^ 4'h6;
                    fe  = 4'(idx * 5);
                    case (k % 4)
                        0: bm = 8'hFF;
                        1: bm = 8'h0F;
                        2: bm = 8'hA5;
                        default: bm = 8'h00;
                    endcase
                    pm = 4'((idx % 15) + 1);
                    preload(pat);
                    set_reg(5, {6'b0, 2'(wm)});
                    do_read("R11 R12 latch load", pat[7:0]);
                    set_reg(3, {3'b0, 2'(f), 3'(rot)});
                    set_reg(0, {4'b0, fv});
                    set_reg(1, {4'b0, fe});
                    set_reg(7, bm);
                    set_reg(8, {4'b0, pm});
                    for (int p = 0; p < 4; p++) begin
                        expw[p*8 +: 8] = exp_plane(wm, f, rot, fv, fe, bm, d, pat[p*8 +: 8], p);
                        expm[p*8 +: 8] = pm[p] ? expw[p*8 +: 8] : pat[p*8 +: 8];
                    end
                    do_write(d, pm, expw);
                    check("R3 only enabled planes updated", mem_word, expm);
                    idx++;
                end
            end
        end

        // R12 normal read select
        set_reg(5, 8'h00);
        preload(32'hC4B3A291);
        for (int s = 0; s < 4; s++) begin
            set_reg(4, 8'(s));
            do_read("R12 plane select", 8'(32'hC4B3A291 >> (8 * s)));
        end

        // R13 colour compare sweep
        pat = 32'hF0CC_AA_55;
        preload(pat);
        set_reg(5, 8'h08);
        for (int dci = 0; dci < 4; dci++) begin
            logic [3:0] dc;
            case (dci)
                0: dc = 4'h0;
                1: dc = 4'h5;
                2: dc = 4'h8;
                default: dc = 4'hF;
            endcase
            set_reg(6, {4'b0, dc});
            for (int c = 0; c < 16; c++) begin
                set_reg(2, 8'(c));
                for (int i = 0; i < 8; i++) begin
                    cmpexp[i] = 1'b1;
                    for (int p = 0; p < 4; p++)
                        if (!dc[p] && (pat[p*8 + i] != c[p])) cmpexp[i] = 1'b0;
                end
                do_read("R13 colour compare", cmpexp);
            end
        end
        set_reg(5, 8'h00);
        set_reg(4, 8'h00);

        // R11 read wins over simultaneous write; R14 busy requests ignored
        set_reg(3, 8'h00); set_reg(7, 8'hFF); set_reg(8, 8'h0F);
        preload(32'h11223344);
        @(negedge clk);
        host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'hEE;
        @(negedge clk);
        host_rd = 1'b0;
        check("R11 read priority mem_rd", {31'b0, mem_rd}, 32'd1);
        check("R11 read priority no we", {28'b0, mem_we}, 32'd0);
        check("R14 busy ready low", {31'b0, host_ready}, 32'd0);
        @(negedge clk);
        check("R14 busy write ignored", {28'b0, mem_we}, 32'd0);
        host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check("R14 rvalid", {31'b0, host_rvalid}, 32'd1);
        check("R14 read data", {24'b0, host_rdata}, 32'h44);
        @(negedge clk);
        check("R14 no write after busy", {28'b0, mem_we}, 32'd0);
        check("R14 no read after busy", {31'b0, mem_rd}, 32'd0);
        check("R14 memory unchanged", mem_word, 32'h11223344);

        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end
endmodule